// File: doc/BRIEF.md
# Transmit Buffer Abort Controller

This block handles cancel requests from software for a bank of transmit message buffers in a CAN-style controller. Each buffer holds a 4-bit code. Software writes a code through a single-buffer write port and reads any buffer's code back through a read port.

The transmit engine tells the block which buffer it currently holds, through an index with a valid qualifier. It also signals arbitration loss, transmit error, successful completion and a freeze request. For every write, the block decides whether to store it, block it and hold an abort pending, or ignore it. It also resolves each pending abort into one of three final states: transmitted, aborted or deactivated. Completion and abort outcomes raise a per-buffer flag. Software clears a flag by writing 1 to it. A single interrupt line combines the flags with a per-buffer mask.

Code values: 4'b0000 is idle (the reset value), 4'b1100 is an active transmit, 4'b1000 is transmitted/inactive, and 4'b1001 is abort. Only 4'b1100 counts as active.

Top module: `tx_abort_ctrl`

## Requirements
- R1: After reset, every buffer code reads 4'b0000, and all flags, pending bits and `irq_out` are 0.
- R2: With `abort_en`=1, writing 4'b1001 to a buffer that the engine does not hold, or that is not active, is stored at once. The code then reads 4'b1001, no flag is set and nothing is pending.
- R3: With `abort_en`=1, writing 4'b1001 to an active buffer (4'b1100) that the engine holds is blocked. The code stays 4'b1100 and the buffer's pending bit is set.
- R4: When the held buffer has a pending abort and `arb_lost`, `tx_err` or `freeze_req` is high, its code becomes 4'b1001, its flag is set and its pending bit clears.
- R5: When `tx_done` is high for the held active buffer, its code becomes 4'b1000, its flag is set and its pending bit clears, whether or not an abort was pending.
- R6: When the held buffer has no pending abort, `arb_lost`, `tx_err` and `freeze_req` change neither its code nor its flag.
- R7: With `abort_en`=1, a write of any code other than 4'b1001 to an active buffer is ignored. The same write to a buffer that is not active is stored.
- R8: With `abort_en`=0, every write is stored as given, even to a held active buffer, and no abort becomes pending.
- R9: Flags clear when 1 is written to the matching bit of `flag_clr`. A flag set in the same cycle as its clear stays set.
- R10: `irq_out` is high exactly when some flag is set and its `irq_mask` bit is 1.
- R11: An engine event and a software write to the same buffer in the same cycle are ordered event first. The write is then judged against the post-event code, and the buffer no longer counts as held.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| abort_en | input | 1 | Global abort mechanism enable |
| wr_en | input | 1 | Software code write strobe |
| wr_idx | input | IDX_W | Buffer index of the write |
| wr_code | input | 4 | Code being written |
| rd_idx | input | IDX_W | Buffer index for read-back |
| rd_code | output | 4 | Code of buffer `rd_idx` |
| flag_clr | input | NUM_BUF | Write-1-to-clear strobes for the flags |
| irq_mask | input | NUM_BUF | Per-buffer interrupt enable |
| lock_vld | input | 1 | Engine holds a buffer |
| lock_idx | input | IDX_W | Index of the held buffer |
| arb_lost | input | 1 | Arbitration lost on the held buffer |
| tx_err | input | 1 | Transmit error on the held buffer |
| tx_done | input | 1 | Held buffer sent successfully |
| freeze_req | input | 1 | Freeze mode entry |
| irq_flags | output | NUM_BUF | Per-buffer event flags |
| pend_abort | output | NUM_BUF | Per-buffer pending-abort bits |
| irq_out | output | 1 | Masked OR of the flags |

## Verification
The bench covers each of the three termination conditions on a pending abort. A design that listened to only some of them would leave the frame marked active with no flag.

It checks that events on a held buffer without a pending abort leave it alone; a design that aborted anyway would cancel frames software never asked to cancel. It checks that a blocked abort stays visible as pending, and that a non-abort write to an active buffer leaves the code unchanged. Against a design that let that write through, the read-back would show a corrupted code.

The same-cycle cases are exercised explicitly. When completion and an abort write coincide, the final code must be 4'b1001 with the flag set; a write-first ordering would instead leave the buffer pending or reading 4'b1000. When a set and a clear of the same flag coincide, the flag must stay set; getting this wrong loses an interrupt.

// File: rtl/txab_pkg.sv
package txab_pkg;

  localparam int CODE_W = 4;

  typedef logic [CODE_W-1:0] code_t;

  localparam code_t CODE_IDLE    = 4'b0000;
  localparam code_t CODE_SENT    = 4'b1000;
  localparam code_t CODE_ABORT   = 4'b1001;
  localparam code_t CODE_TX_LIVE = 4'b1100;

  typedef enum logic [2:0] {
    WR_NONE,
    WR_STORE,
    WR_DEACT,
    WR_BLOCK,
    WR_REJECT
  } wr_res_e;

  // A buffer is a live transmit only while it carries the live code.
  function automatic logic f_tx_active(code_t c);
    return c == CODE_TX_LIVE;
  endfunction

  // Decide what a software code write does, given the state after engine events.
  function automatic wr_res_e f_wr_resolve(logic en, logic wr, code_t req,
                                           logic active, logic held);
    if (!wr)                return WR_NONE;
    if (!en)                return WR_STORE;
    if (req == CODE_ABORT)  return (active && held) ? WR_BLOCK : WR_DEACT;
    if (active)             return WR_REJECT;
    return WR_STORE;
  endfunction

endpackage

// File: rtl/txab_onehot.sv
module txab_onehot #(
  parameter int N = 8,
  parameter int W = 3
) (
  input  logic         vld,
  input  logic [W-1:0] idx,
  output logic [N-1:0] hit
);
  for (genvar g = 0; g < N; g++) begin : g_hit
    assign hit[g] = vld && (idx == W'(g));
  end
endmodule

// File: rtl/txab_buf_slot.sv
module txab_buf_slot
  import txab_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  abort_en,
  input  logic  wr_hit,
  input  code_t wr_code,
  input  logic  lock_hit,
  input  logic  done_in,
  input  logic  stop_in,
  input  logic  clr_in,
  output code_t code_q,
  output logic  pend_q,
  output logic  flag_q,
  output logic  ev_done,
  output logic  ev_abort,
  output logic  ev_block,
  output logic  ev_deact,
  output logic  ev_reject
);
  code_t   code_mid, code_d;
  logic    pend_d, flag_d, resolved;
  wr_res_e wr_res;

  always_comb begin
    ev_done  = lock_hit && done_in && f_tx_active(code_q);
    ev_abort = lock_hit && !done_in && stop_in && pend_q && f_tx_active(code_q);
    resolved = ev_done || ev_abort;

    // Engine events are applied first; the write sees the result.
    if (ev_done)       code_mid = CODE_SENT;
    else if (ev_abort) code_mid = CODE_ABORT;
    else               code_mid = code_q;

    wr_res = f_wr_resolve(abort_en, wr_hit, wr_code,
                          f_tx_active(code_mid), lock_hit && !resolved);

    ev_block  = (wr_res == WR_BLOCK);
    ev_deact  = (wr_res == WR_DEACT);
    ev_reject = (wr_res == WR_REJECT);

    code_d = (wr_res == WR_STORE || wr_res == WR_DEACT) ? wr_code : code_mid;

    if (resolved)      pend_d = 1'b0;
    else if (ev_block) pend_d = 1'b1;
    else               pend_d = pend_q;

    flag_d = resolved || (flag_q && !clr_in);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      code_q <= CODE_IDLE;
      pend_q <= 1'b0;
      flag_q <= 1'b0;
    end else begin
      code_q <= code_d;
      pend_q <= pend_d;
      flag_q <= flag_d;
    end
  end
endmodule

// File: rtl/txab_irq_or.sv
module txab_irq_or #(
  parameter int N = 8
) (
  input  logic [N-1:0] flags,
  input  logic [N-1:0] mask,
  output logic         irq
);
  assign irq = |(flags & mask);
endmodule

// File: rtl/tx_abort_ctrl.sv
module tx_abort_ctrl
  import txab_pkg::*;
#(
  parameter int  NUM_BUF = 8,
  localparam int IDX_W   = (NUM_BUF > 1) ? $clog2(NUM_BUF) : 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               abort_en,
  input  logic               wr_en,
  input  logic [IDX_W-1:0]   wr_idx,
  input  logic [CODE_W-1:0]  wr_code,
  input  logic [IDX_W-1:0]   rd_idx,
  output logic [CODE_W-1:0]  rd_code,
  input  logic [NUM_BUF-1:0] flag_clr,
  input  logic [NUM_BUF-1:0] irq_mask,
  input  logic               lock_vld,
  input  logic [IDX_W-1:0]   lock_idx,
  input  logic               arb_lost,
  input  logic               tx_err,
  input  logic               tx_done,
  input  logic               freeze_req,
  output logic [NUM_BUF-1:0] irq_flags,
  output logic [NUM_BUF-1:0] pend_abort,
  output logic               irq_out
);
  logic [NUM_BUF-1:0] wr_hit_v, lock_hit_v;
  logic [NUM_BUF-1:0] ev_done_v, ev_abort_v, ev_block_v, ev_deact_v, ev_reject_v;
  logic [NUM_BUF*CODE_W-1:0] code_flat;
  code_t code_arr [NUM_BUF];
  logic  stop_any;

  assign stop_any = arb_lost || tx_err || freeze_req;

  txab_onehot #(.N(NUM_BUF), .W(IDX_W)) u_wr_dec (
    .vld(wr_en), .idx(wr_idx), .hit(wr_hit_v)
  );

  txab_onehot #(.N(NUM_BUF), .W(IDX_W)) u_lock_dec (
    .vld(lock_vld), .idx(lock_idx), .hit(lock_hit_v)
  );

  for (genvar b = 0; b < NUM_BUF; b++) begin : g_slot
    txab_buf_slot u_slot (
      .clk      (clk),
      .rst_n    (rst_n),
      .abort_en (abort_en),
      .wr_hit   (wr_hit_v[b]),
      .wr_code  (wr_code),
      .lock_hit (lock_hit_v[b]),
      .done_in  (tx_done),
      .stop_in  (stop_any),
      .clr_in   (flag_clr[b]),
      .code_q   (code_arr[b]),
      .pend_q   (pend_abort[b]),
      .flag_q   (irq_flags[b]),
      .ev_done  (ev_done_v[b]),
      .ev_abort (ev_abort_v[b]),
      .ev_block (ev_block_v[b]),
      .ev_deact (ev_deact_v[b]),
      .ev_reject(ev_reject_v[b])
    );
    assign code_flat[b*CODE_W +: CODE_W] = code_arr[b];
  end

  always_comb begin
    rd_code = CODE_IDLE;
    for (int i = 0; i < NUM_BUF; i++) begin
      if (rd_idx == IDX_W'(i)) rd_code = code_arr[i];
    end
  end

  txab_irq_or #(.N(NUM_BUF)) u_irq (
    .flags(irq_flags), .mask(irq_mask), .irq(irq_out)
  );
endmodule

// File: rtl/txab_chk.sv
module txab_chk
  import txab_pkg::*;
#(
  parameter int NUM_BUF = 8
) (
  input logic                      clk,
  input logic                      rst_n,
  input logic                      abort_en,
  input logic [NUM_BUF-1:0]        irq_flags,
  input logic [NUM_BUF-1:0]        pend_abort,
  input logic [NUM_BUF*CODE_W-1:0] code_flat,
  input logic [NUM_BUF-1:0]        ev_done_v,
  input logic [NUM_BUF-1:0]        ev_abort_v,
  input logic [NUM_BUF-1:0]        ev_block_v,
  input logic [NUM_BUF-1:0]        ev_deact_v,
  input logic [NUM_BUF-1:0]        ev_reject_v
);
  assert_single_resolve_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(ev_done_v | ev_abort_v));

  assert_legacy_no_block_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !abort_en |-> (ev_block_v == '0));

  for (genvar i = 0; i < NUM_BUF; i++) begin : g_chk
    assert_deact_code_R2: assert property (@(posedge clk) disable iff (!rst_n)
      ev_deact_v[i] |=> code_flat[i*CODE_W +: CODE_W] == CODE_ABORT);

    assert_block_pends_R3: assert property (@(posedge clk) disable iff (!rst_n)
      ev_block_v[i] |=> pend_abort[i] && $stable(code_flat[i*CODE_W +: CODE_W]));

    assert_abort_flags_R4: assert property (@(posedge clk) disable iff (!rst_n)
      ev_abort_v[i] |=> irq_flags[i] && !pend_abort[i]);

    assert_done_flags_R5: assert property (@(posedge clk) disable iff (!rst_n)
      ev_done_v[i] |=> irq_flags[i] && !pend_abort[i]);

    assert_reject_keeps_code_R7: assert property (@(posedge clk) disable iff (!rst_n)
      ev_reject_v[i] |=> $stable(code_flat[i*CODE_W +: CODE_W]));
  end
endmodule

bind tx_abort_ctrl txab_chk #(.NUM_BUF(NUM_BUF)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .abort_en   (abort_en),
  .irq_flags  (irq_flags),
  .pend_abort (pend_abort),
  .code_flat  (code_flat),
  .ev_done_v  (ev_done_v),
  .ev_abort_v (ev_abort_v),
  .ev_block_v (ev_block_v),
  .ev_deact_v (ev_deact_v),
  .ev_reject_v(ev_reject_v)
);

// File: tb/tx_abort_ctrl_tb.sv
`timescale 1ns/1ps
module tx_abort_ctrl_tb;
  localparam int NB = 8;
  localparam logic [3:0] C_IDLE = 4'b0000;
  localparam logic [3:0] C_LIVE = 4'b1100;
  localparam logic [3:0] C_SENT = 4'b1000;
  localparam logic [3:0] C_ABT  = 4'b1001;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic abort_en = 1'b0, wr_en = 1'b0, lock_vld = 1'b0;
  logic arb_lost = 1'b0, tx_err = 1'b0, tx_done = 1'b0, freeze_req = 1'b0;
  logic [2:0] wr_idx = '0, rd_idx = '0, lock_idx = '0;
  logic [3:0] wr_code = '0;
  logic [3:0] rd_code;
  logic [NB-1:0] flag_clr = '0, irq_mask = '0;
  logic [NB-1:0] irq_flags, pend_abort;
  logic irq_out;

  int n_checks = 0;
  int n_fails  = 0;

  // Scoreboard queues; index -1 marks an interrupt-line item.
  int         q_idx  [$];
  logic [3:0] q_code [$];
  logic       q_flag [$];
  logic       q_pend [$];
  string      q_req  [$];

  always #5 clk = ~clk;

  tx_abort_ctrl #(.NUM_BUF(NB)) u_dut (
    .clk(clk), .rst_n(rst_n), .abort_en(abort_en),
    .wr_en(wr_en), .wr_idx(wr_idx), .wr_code(wr_code),
    .rd_idx(rd_idx), .rd_code(rd_code),
    .flag_clr(flag_clr), .irq_mask(irq_mask),
    .lock_vld(lock_vld), .lock_idx(lock_idx),
    .arb_lost(arb_lost), .tx_err(tx_err), .tx_done(tx_done), .freeze_req(freeze_req),
    .irq_flags(irq_flags), .pend_abort(pend_abort), .irq_out(irq_out)
  );

  // Monitor: pops expected items away from the rising edge and compares.
  always @(negedge clk) begin
    while (q_idx.size() > 0) begin
      automatic int         b  = q_idx.pop_front();
      automatic logic [3:0] ec = q_code.pop_front();
      automatic logic       ef = q_flag.pop_front();
      automatic logic       ep = q_pend.pop_front();
      automatic string      rq = q_req.pop_front();
      n_checks++;
      if (b < 0) begin
        if (irq_out !== ef) begin
          n_fails++;
          $display("FAIL %s: irq_out=%b expected %b", rq, irq_out, ef);
        end
      end else begin
        rd_idx = 3'(b);
        #0.5;
        if (rd_code !== ec || irq_flags[b] !== ef || pend_abort[b] !== ep) begin
          n_fails++;
          $display("FAIL %s: buf%0d code=%b flag=%b pend=%b expected code=%b flag=%b pend=%b",
                   rq, b, rd_code, irq_flags[b], pend_abort[b], ec, ef, ep);
        end
      end
    end
  end

  task automatic exp_buf(input int b, input logic [3:0] c, input logic f,
                         input logic p, input string rq);
    q_idx.push_back(b); q_code.push_back(c); q_flag.push_back(f);
    q_pend.push_back(p); q_req.push_back(rq);
  endtask

  task automatic exp_irq(input logic v, input string rq);
    q_idx.push_back(-1); q_code.push_back(4'b0); q_flag.push_back(v);
    q_pend.push_back(1'b0); q_req.push_back(rq);
  endtask

  task automatic wr(input int b, input logic [3:0] c);
    wr_en = 1'b1; wr_idx = 3'(b); wr_code = c;
  endtask

  // One clock: inputs set before it are seen at the edge, strobes drop after it.
  task automatic cyc();
    @(posedge clk); #1;
    wr_en = 1'b0; flag_clr = '0;
    arb_lost = 1'b0; tx_err = 1'b0; tx_done = 1'b0; freeze_req = 1'b0;
  endtask

  task automatic settle();
    wait (q_idx.size() == 0);
    #1;
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_fails++;
    $display("FAIL watchdog: run did not complete, expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    // R1 reset state
    exp_buf(0, C_IDLE, 0, 0, "R1");
    exp_buf(7, C_IDLE, 0, 0, "R1");
    exp_irq(1'b0, "R1");
    settle();

    abort_en = 1'b1;
    irq_mask = 8'hDF;

    // R7 store onto idle buffer; R2 abort on a buffer the engine does not hold
    wr(1, C_LIVE); cyc(); exp_buf(1, C_LIVE, 0, 0, "R7 store to idle"); settle();
    wr(1, C_ABT);  cyc(); exp_buf(1, C_ABT, 0, 0, "R2 deactivate"); settle();

    // R3 blocked abort on held live buffer
    wr(2, C_LIVE); cyc();
    lock_vld = 1'b1; lock_idx = 3'd2;
    wr(2, C_ABT); cyc(); exp_buf(2, C_LIVE, 0, 1, "R3 blocked"); settle();
    // R7 other code to live buffer ignored
    wr(2, C_SENT); cyc(); exp_buf(2, C_LIVE, 0, 1, "R7 reject"); settle();
    // R4 arbitration loss resolves the abort
    arb_lost = 1'b1; cyc();
    exp_buf(2, C_ABT, 1, 0, "R4 arb loss"); exp_irq(1'b1, "R10 flag raised"); settle();
    // R9 clear
    flag_clr = 8'h04; cyc();
    exp_buf(2, C_ABT, 0, 0, "R9 clear"); exp_irq(1'b0, "R10 cleared"); settle();

    // R5 completion wins over a pending abort
    wr(3, C_LIVE); cyc(); lock_idx = 3'd3;
    wr(3, C_ABT); cyc(); exp_buf(3, C_LIVE, 0, 1, "R3 blocked b3"); settle();
    tx_done = 1'b1; cyc(); exp_buf(3, C_SENT, 1, 0, "R5 transmitted"); settle();
    flag_clr = 8'h08; cyc(); settle();

    // R4 transmit error
    wr(4, C_LIVE); cyc(); lock_idx = 3'd4;
    wr(4, C_ABT); cyc();
    tx_err = 1'b1; cyc(); exp_buf(4, C_ABT, 1, 0, "R4 tx error"); settle();
    flag_clr = 8'h10; cyc(); settle();

    // R4 freeze; R10 masked flag leaves irq low
    wr(5, C_LIVE); cyc(); lock_idx = 3'd5;
    wr(5, C_ABT); cyc();
    freeze_req = 1'b1; cyc();
    exp_buf(5, C_ABT, 1, 0, "R4 freeze"); exp_irq(1'b0, "R10 masked"); settle();

    // R6 events without pending abort do nothing
    wr(6, C_LIVE); cyc(); lock_idx = 3'd6;
    arb_lost = 1'b1; tx_err = 1'b1; cyc();
    exp_buf(6, C_LIVE, 0, 0, "R6 no pending"); settle();
    freeze_req = 1'b1; cyc();
    exp_buf(6, C_LIVE, 0, 0, "R6 freeze no pending"); settle();

    // R11 completion and abort write in the same cycle
    tx_done = 1'b1; wr(6, C_ABT); cyc();
    exp_buf(6, C_ABT, 1, 0, "R11 event first"); exp_irq(1'b1, "R10 unmasked"); settle();

    // R9 set beats clear in the same cycle
    wr(7, C_LIVE); cyc(); lock_idx = 3'd7;
    tx_done = 1'b1; flag_clr = 8'hC0; cyc();
    exp_buf(7, C_SENT, 1, 0, "R9 set wins");
    exp_buf(6, C_ABT, 0, 0, "R9 clear other");
    exp_irq(1'b1, "R10 flag7"); settle();

    // R8 legacy writes
    abort_en = 1'b0;
    wr(0, C_LIVE); cyc(); lock_idx = 3'd0;
    wr(0, C_SENT); cyc(); exp_buf(0, C_SENT, 0, 0, "R8 store on held"); settle();
    wr(0, C_LIVE); cyc();
    wr(0, C_ABT);  cyc(); exp_buf(0, C_ABT, 0, 0, "R8 abort stored, no pending"); settle();

    // R2 abort on live buffer while engine holds a different one
    abort_en = 1'b1;
    wr(1, C_LIVE); cyc();
    wr(1, C_ABT);  cyc(); exp_buf(1, C_ABT, 0, 0, "R2 other held"); settle();

    finish_run();
  end
endmodule